// File: doc/BRIEF.md
# Repeated String Transfer Sequencer

This block executes string-style data transfers in hardware. It holds a source pointer, a destination pointer, a repeat counter, an accumulator, a port address register and a direction flag. One command starts one of five transfers. A load reads memory into the accumulator. A store writes the accumulator to memory. A move copies memory to memory. Port input copies a port value into memory, and port output copies a memory value to a port. Each element is a byte, a word or a doubleword.

Each element is carried over two request channels, one for memory and one for ports. Each channel has a valid/ready handshake, and read data is returned in the same cycle as the handshake. After each element, only the pointers that the transfer used move by the element size, in the direction that the flag selects. In repeat mode the counter counts elements down to zero. Every memory access carries a segment tag. Destination accesses are always tagged with the extra segment. Source accesses use the data segment unless an override is given.

The pointers, counter, accumulator and port register are loaded through `ld_regs` while the block is idle, and they stay visible on the outputs. A one-cycle `done` marks the end of each command.

Top module: `strxfer_seq`

## Requirements
- R1: With the direction flag at 0 (after `dir_clr`) the used pointers increase after each element; with it at 1 (after `dir_set`) they decrease; `dir_flag` shows the flag.
- R2: The pointer step follows `size`: 0 gives 1, 1 gives 2, 2 or 3 gives 4.
- R3: Only the pointers in use change. A load (op 0) and port output (op 4) move only the source pointer. A store (op 1) and port input (op 3) move only the destination pointer. A move (op 2) moves both.
- R4: Memory writes carry segment tag 0 (extra). Memory reads carry tag 3 (data) unless `seg_ovr_en` is set, in which case they carry `seg_ovr`.
- R5: A load merges the read data into the low 8 bits of the accumulator for a byte, into the low 16 bits for a word, or into all 32 bits for a doubleword. A store writes the accumulator at the destination pointer.
- R6: A move reads at the source pointer and writes the read value at the destination pointer.
- R7: Port input reads the port address in the port register and writes that value to memory at the destination pointer. Port output reads memory at the source pointer and writes that value to the port address. At most one of the two channels requests in any cycle.
- R8: In repeat mode the counter drops by exactly 1 per element, and the command ends with `done` when the counter reaches 0. Without repeat, one element is moved and the counter is untouched.
- R9: A repeat command started with the counter at 0 moves no element, changes no pointer or counter, and still pulses `done`.
- R10: A repeat request on a load pulses `rep_err`. The load then runs once and leaves the counter unchanged.
- R11: A request that is not yet accepted stays valid, with its address, write flag and write data held, until ready.
- R12: Pointer stepping wraps modulo 2^32 in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_regs | input | 1 | Load the register inputs below (accepted when idle) |
| ld_src | input | 32 | Source pointer value |
| ld_dst | input | 32 | Destination pointer value |
| ld_cnt | input | 32 | Repeat counter value |
| ld_acc | input | 32 | Accumulator value |
| ld_port | input | 16 | Port address value |
| dir_clr | input | 1 | Clear the direction flag (accepted when idle) |
| dir_set | input | 1 | Set the direction flag (accepted when idle; wins over clear) |
| start | input | 1 | Start a command (accepted when idle) |
| op | input | 3 | 0 load, 1 store, 2 move, 3 port in, 4 port out; other codes end at once |
| size | input | 2 | 0 byte, 1 word, 2/3 doubleword |
| rep | input | 1 | Repeat until the counter reaches zero |
| seg_ovr_en | input | 1 | Use `seg_ovr` for source accesses |
| seg_ovr | input | 2 | Source segment tag override |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| rep_err | output | 1 | One-cycle pulse: repeat was requested on a load |
| dir_flag | output | 1 | Direction flag |
| src_ptr | output | 32 | Source pointer |
| dst_ptr | output | 32 | Destination pointer |
| count | output | 32 | Repeat counter |
| acc | output | 32 | Accumulator |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | Memory write (1) or read (0) |
| mem_req_addr | output | 32 | Memory address |
| mem_req_seg | output | 2 | Segment tag |
| mem_req_size | output | 2 | Element size |
| mem_req_wdata | output | 32 | Memory write data |
| mem_rsp_data | input | 32 | Memory read data, valid with the handshake |
| io_req_valid | output | 1 | Port request valid |
| io_req_ready | input | 1 | Port request accepted |
| io_req_we | output | 1 | Port write (1) or read (0) |
| io_req_addr | output | 16 | Port address |
| io_req_size | output | 2 | Element size |
| io_req_wdata | output | 32 | Port write data |
| io_rsp_data | input | 32 | Port read data, valid with the handshake |

## Verification
The acceptance of an element's last write, the pointer step and the counter's test for zero all happen in the same cycle. That cycle decides whether another element is issued or `done` is pulsed. Repeat runs with counts of 1, 2 and 3 provoke this, under handshake latencies of zero, one and two cycles. The bench judges each run by the number of accesses on each channel and by the final pointers and counter. A second collision is the repeat error on a load, which arrives together with the start of that load's single element. The bench judges it by the error pulse, exactly one read, a single pointer step and an unchanged counter.

// File: rtl/strxfer_pkg.sv
package strxfer_pkg;
    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_MOVE  = 3'd2,
        OP_PIN   = 3'd3,
        OP_POUT  = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } st_e;

    localparam logic [1:0] SEG_EXTRA = 2'd0;
    localparam logic [1:0] SEG_CODE  = 2'd1;
    localparam logic [1:0] SEG_STACK = 2'd2;
    localparam logic [1:0] SEG_DATA  = 2'd3;
endpackage

// File: rtl/strxfer_step.sv
module strxfer_step #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] ptr,
    input  logic [1:0]    size,
    input  logic          dir,
    output logic [AW-1:0] nxt
);
    logic [AW-1:0] step;

    always_comb begin
        if (size[1])      step = AW'(4);
        else if (size[0]) step = AW'(2);
        else              step = AW'(1);
        nxt = dir ? (ptr - step) : (ptr + step);
    end
endmodule

// File: rtl/strxfer_seq.sv
module strxfer_seq
    import strxfer_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 32,
    parameter int DW = 32,
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_regs,
    input  logic [AW-1:0] ld_src,
    input  logic [AW-1:0] ld_dst,
    input  logic [CW-1:0] ld_cnt,
    input  logic [DW-1:0] ld_acc,
    input  logic [PW-1:0] ld_port,
    input  logic          dir_clr,
    input  logic          dir_set,
    input  logic          start,
    input  logic [2:0]    op,
    input  logic [1:0]    size,
    input  logic          rep,
    input  logic          seg_ovr_en,
    input  logic [1:0]    seg_ovr,
    output logic          busy,
    output logic          done,
    output logic          rep_err,
    output logic          dir_flag,
    output logic [AW-1:0] src_ptr,
    output logic [AW-1:0] dst_ptr,
    output logic [CW-1:0] count,
    output logic [DW-1:0] acc,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic          mem_req_we,
    output logic [AW-1:0] mem_req_addr,
    output logic [1:0]    mem_req_seg,
    output logic [1:0]    mem_req_size,
    output logic [DW-1:0] mem_req_wdata,
    input  logic [DW-1:0] mem_rsp_data,
    output logic          io_req_valid,
    input  logic          io_req_ready,
    output logic          io_req_we,
    output logic [PW-1:0] io_req_addr,
    output logic [1:0]    io_req_size,
    output logic [DW-1:0] io_req_wdata,
    input  logic [DW-1:0] io_rsp_data
);
    localparam int NPTR = 2;  // 0: source, 1: destination

    typedef struct packed {
        st_e             st;
        logic [AW-1:0]   src;
        logic [AW-1:0]   dst;
        logic [CW-1:0]   cnt;
        logic [DW-1:0]   acc;
        logic [DW-1:0]   tmp;
        logic [PW-1:0]   port;
        logic            dir;
        op_e             op;
        logic [1:0]      size;
        logic            rep;
        logic [1:0]      sseg;
        logic            done;
        logic            err;
    } state_t;

    state_t s_q, s_d;

    // Pointer steppers, one per pointer
    logic [AW-1:0] ptr_cur [NPTR];
    logic [AW-1:0] ptr_nxt [NPTR];
    assign ptr_cur[0] = s_q.src;
    assign ptr_cur[1] = s_q.dst;

    for (genvar g = 0; g < NPTR; g++) begin : g_step
        strxfer_step #(.AW(AW)) u_step (
            .ptr  (ptr_cur[g]),
            .size (s_q.size),
            .dir  (s_q.dir),
            .nxt  (ptr_nxt[g])
        );
    end

    logic uses_src, uses_dst, rd_on_io, wr_on_io;
    logic rd_fire, wr_fire, elem_end;
    logic [DW-1:0] rd_data, merged;
    logic [CW-1:0] cnt_dec;
    st_e first_ph;

    always_comb begin
        uses_src = (s_q.op == OP_LOAD) || (s_q.op == OP_MOVE) || (s_q.op == OP_POUT);
        uses_dst = (s_q.op == OP_STORE) || (s_q.op == OP_MOVE) || (s_q.op == OP_PIN);
        rd_on_io = (s_q.op == OP_PIN);
        wr_on_io = (s_q.op == OP_POUT);
        first_ph = (s_q.op == OP_STORE) ? ST_WR : ST_RD;

        mem_req_valid = ((s_q.st == ST_RD) && !rd_on_io) || ((s_q.st == ST_WR) && !wr_on_io);
        io_req_valid  = ((s_q.st == ST_RD) && rd_on_io)  || ((s_q.st == ST_WR) && wr_on_io);
        mem_req_we    = (s_q.st == ST_WR);
        io_req_we     = (s_q.st == ST_WR);
        mem_req_addr  = (s_q.st == ST_WR) ? s_q.dst : s_q.src;
        mem_req_seg   = (s_q.st == ST_WR) ? SEG_EXTRA : s_q.sseg;
        mem_req_size  = s_q.size;
        mem_req_wdata = (s_q.op == OP_STORE) ? s_q.acc : s_q.tmp;
        io_req_addr   = s_q.port;
        io_req_size   = s_q.size;
        io_req_wdata  = s_q.tmp;

        rd_fire = (s_q.st == ST_RD) && (rd_on_io ? io_req_ready : mem_req_ready);
        wr_fire = (s_q.st == ST_WR) && (wr_on_io ? io_req_ready : mem_req_ready);
        rd_data = rd_on_io ? io_rsp_data : mem_rsp_data;

        if (s_q.size[1])      merged = rd_data;
        else if (s_q.size[0]) merged = {s_q.acc[DW-1:16], rd_data[15:0]};
        else                  merged = {s_q.acc[DW-1:8],  rd_data[7:0]};

        elem_end = wr_fire || (rd_fire && (s_q.op == OP_LOAD));
        cnt_dec  = s_q.cnt - CW'(1);
    end

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.err  = 1'b0;

        case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.op   = op_e'(op);
                    s_d.size = size;
                    s_d.sseg = seg_ovr_en ? seg_ovr : SEG_DATA;
                    s_d.err  = rep && (op == OP_LOAD);
                    s_d.rep  = rep && (op != OP_LOAD);
                    if (op > OP_POUT)                         s_d.done = 1'b1;
                    else if (s_d.rep && (s_q.cnt == '0))      s_d.done = 1'b1;
                    else if (op == OP_STORE)                  s_d.st   = ST_WR;
                    else                                      s_d.st   = ST_RD;
                end else begin
                    if (ld_regs) begin
                        s_d.src  = ld_src;
                        s_d.dst  = ld_dst;
                        s_d.cnt  = ld_cnt;
                        s_d.acc  = ld_acc;
                        s_d.port = ld_port;
                    end
                    if (dir_set)      s_d.dir = 1'b1;
                    else if (dir_clr) s_d.dir = 1'b0;
                end
            end
            ST_RD: begin
                if (rd_fire) begin
                    if (s_q.op == OP_LOAD) s_d.acc = merged;
                    else begin
                        s_d.tmp = rd_data;
                        s_d.st  = ST_WR;
                    end
                end
            end
            default: ;
        endcase

        if (elem_end) begin
            if (uses_src) s_d.src = ptr_nxt[0];
            if (uses_dst) s_d.dst = ptr_nxt[1];
            if (s_q.rep) begin
                s_d.cnt = cnt_dec;
                if (cnt_dec == '0) begin
                    s_d.st   = ST_IDLE;
                    s_d.done = 1'b1;
                end else begin
                    s_d.st = first_ph;
                end
            end else begin
                s_d.st   = ST_IDLE;
                s_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, op: OP_LOAD, sseg: SEG_DATA, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy     = (s_q.st != ST_IDLE);
    assign done     = s_q.done;
    assign rep_err  = s_q.err;
    assign dir_flag = s_q.dir;
    assign src_ptr  = s_q.src;
    assign dst_ptr  = s_q.dst;
    assign count    = s_q.cnt;
    assign acc      = s_q.acc;

    // Handshake hold rules
    a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
            && $stable(mem_req_we) && $stable(mem_req_wdata));
    a_r11_io_hold: assert property (@(posedge clk) disable iff (!rst_n)
        io_req_valid && !io_req_ready |=> io_req_valid && $stable(io_req_addr)
            && $stable(io_req_we) && $stable(io_req_wdata));
    // Destination writes are always in the extra segment
    a_r4_dst_extra: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_we |-> mem_req_seg == SEG_EXTRA);
    // Channels never request together
    a_r7_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req_valid, io_req_valid}));
    // Counter only steps down by one during a command
    a_r8_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) && (count != $past(count)) |-> count == $past(count) - CW'(1));
    // A rejected repeat still runs the single load
    a_r10_err_runs: assert property (@(posedge clk) disable iff (!rst_n)
        rep_err |-> busy && !done);
    // Pointers frozen while idle except through register load
    a_r3_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(busy) && !$past(ld_regs) |-> $stable(src_ptr) && $stable(dst_ptr));
endmodule

// File: tb/strxfer_seq_tb.sv
module strxfer_seq_tb;
    typedef struct packed {
        logic [2:0]  op;
        logic [1:0]  sz;
        logic        dir;
        logic        rep;
        logic [31:0] cnt;
        logic [31:0] si;
        logic [31:0] di;
        logic        oen;
        logic [1:0]  oseg;
        logic [31:0] e_si;
        logic [31:0] e_di;
        logic [31:0] e_cnt;
        logic [7:0]  e_rd;
        logic [7:0]  e_wr;
        logic [7:0]  e_io;
        logic [31:0] e_waddr;
        logic [31:0] e_wdata;
        logic [1:0]  e_rseg;
        logic        e_err;
        logic [31:0] e_acc;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        // store byte, up, repeat 3
        '{3'd1, 2'd0, 1'b0, 1'b1, 32'd3, 32'h100, 32'h200, 1'b0, 2'd0,
          32'h100, 32'h203, 32'd0, 8'd0, 8'd3, 8'd0, 32'h202, 32'h11223344, 2'd0, 1'b0, 32'h11223344},
        // load dword, down, single
        '{3'd0, 2'd2, 1'b1, 1'b0, 32'd5, 32'h300, 32'h400, 1'b0, 2'd0,
          32'h2FC, 32'h400, 32'd5, 8'd1, 8'd0, 8'd0, 32'h0, 32'h0, 2'd3, 1'b0, 32'hC3C30300},
        // move word, up, repeat 2, stack override
        '{3'd2, 2'd1, 1'b0, 1'b1, 32'd2, 32'h1000, 32'h2000, 1'b1, 2'd2,
          32'h1004, 32'h2004, 32'd0, 8'd2, 8'd2, 8'd0, 32'h2002, 32'hC3C31002, 2'd2, 1'b0, 32'h11223344},
        // port in dword, down, repeat 2
        '{3'd3, 2'd2, 1'b1, 1'b1, 32'd2, 32'h50, 32'h80, 1'b0, 2'd0,
          32'h50, 32'h78, 32'd0, 8'd0, 8'd2, 8'd2, 32'h7C, 32'h123403AC, 2'd0, 1'b0, 32'h11223344},
        // port out byte, down, repeat 3
        '{3'd4, 2'd0, 1'b1, 1'b1, 32'd3, 32'h10, 32'h20, 1'b0, 2'd0,
          32'h0D, 32'h20, 32'd0, 8'd3, 8'd0, 8'd3, 32'h3AC, 32'hC3C3000E, 2'd3, 1'b0, 32'h11223344},
        // move with repeat and zero count
        '{3'd2, 2'd0, 1'b0, 1'b1, 32'd0, 32'h40, 32'h60, 1'b0, 2'd0,
          32'h40, 32'h60, 32'd0, 8'd0, 8'd0, 8'd0, 32'h0, 32'h0, 2'd0, 1'b0, 32'h11223344},
        // load byte with repeat: rejected, runs once
        '{3'd0, 2'd0, 1'b0, 1'b1, 32'd4, 32'h10, 32'h20, 1'b0, 2'd0,
          32'h11, 32'h20, 32'd4, 8'd1, 8'd0, 8'd0, 32'h0, 32'h0, 2'd3, 1'b1, 32'h11223310},
        // store dword wrapping upward
        '{3'd1, 2'd2, 1'b0, 1'b0, 32'd9, 32'h5, 32'hFFFFFFFE, 1'b0, 2'd0,
          32'h5, 32'h2, 32'd9, 8'd0, 8'd1, 8'd0, 32'hFFFFFFFE, 32'h11223344, 2'd0, 1'b0, 32'h11223344},
        // load word wrapping downward, code override
        '{3'd0, 2'd1, 1'b1, 1'b0, 32'd7, 32'h0, 32'h8, 1'b1, 2'd1,
          32'hFFFFFFFE, 32'h8, 32'd7, 8'd1, 8'd0, 8'd0, 32'h0, 32'h0, 2'd1, 1'b0, 32'h11220000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        ld_regs = 0, dir_clr = 0, dir_set = 0, start = 0, rep = 0, seg_ovr_en = 0;
    logic [31:0] ld_src = 0, ld_dst = 0, ld_cnt = 0, ld_acc = 0;
    logic [15:0] ld_port = 0;
    logic [2:0]  op = 0;
    logic [1:0]  size = 0, seg_ovr = 0;
    logic        busy, done, rep_err, dir_flag;
    logic [31:0] src_ptr, dst_ptr, count, acc;
    logic        mem_req_valid, mem_req_ready, mem_req_we;
    logic [31:0] mem_req_addr, mem_req_wdata, mem_rsp_data;
    logic [1:0]  mem_req_seg, mem_req_size, io_req_size;
    logic        io_req_valid, io_req_ready, io_req_we;
    logic [15:0] io_req_addr;
    logic [31:0] io_req_wdata, io_rsp_data;

    strxfer_seq u_dut (
        .clk(clk), .rst_n(rst_n), .ld_regs(ld_regs), .ld_src(ld_src), .ld_dst(ld_dst),
        .ld_cnt(ld_cnt), .ld_acc(ld_acc), .ld_port(ld_port), .dir_clr(dir_clr),
        .dir_set(dir_set), .start(start), .op(op), .size(size), .rep(rep),
        .seg_ovr_en(seg_ovr_en), .seg_ovr(seg_ovr), .busy(busy), .done(done),
        .rep_err(rep_err), .dir_flag(dir_flag), .src_ptr(src_ptr), .dst_ptr(dst_ptr),
        .count(count), .acc(acc), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
        .mem_req_addr(mem_req_addr), .mem_req_seg(mem_req_seg),
        .mem_req_size(mem_req_size), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_data(mem_rsp_data), .io_req_valid(io_req_valid),
        .io_req_ready(io_req_ready), .io_req_we(io_req_we), .io_req_addr(io_req_addr),
        .io_req_size(io_req_size), .io_req_wdata(io_req_wdata), .io_rsp_data(io_rsp_data)
    );

    // Bus responders with programmable latency
    int lat = 0;
    int mwait = 0, iwait = 0;
    assign mem_req_ready = mem_req_valid && (mwait >= lat);
    assign io_req_ready  = io_req_valid && (iwait >= lat);
    assign mem_rsp_data  = mem_req_addr ^ 32'hC3C30000;
    assign io_rsp_data   = 32'h12340000 | {16'h0, io_req_addr};

    int nrd = 0, nwr = 0, nio = 0, ndone = 0, nerr = 0, hold_bad = 0;
    logic [31:0] lw_addr = 0, lw_data = 0;
    logic [1:0]  lrseg = 0;
    logic        m_wait_p = 0, i_wait_p = 0;
    logic [31:0] m_addr_p = 0;
    logic [15:0] i_addr_p = 0;

    always @(posedge clk) begin
        mwait <= (mem_req_valid && !mem_req_ready) ? mwait + 1 : 0;
        iwait <= (io_req_valid && !io_req_ready) ? iwait + 1 : 0;
        if (m_wait_p && (!mem_req_valid || mem_req_addr != m_addr_p)) hold_bad <= hold_bad + 1;
        if (i_wait_p && (!io_req_valid || io_req_addr != i_addr_p))  hold_bad <= hold_bad + 1;
        m_wait_p <= rst_n && mem_req_valid && !mem_req_ready;
        i_wait_p <= rst_n && io_req_valid && !io_req_ready;
        m_addr_p <= mem_req_addr;
        i_addr_p <= io_req_addr;
        if (mem_req_valid && mem_req_ready) begin
            if (mem_req_we) begin
                nwr <= nwr + 1; lw_addr <= mem_req_addr; lw_data <= mem_req_wdata;
            end else begin
                nrd <= nrd + 1; lrseg <= mem_req_seg;
            end
        end
        if (io_req_valid && io_req_ready) begin
            nio <= nio + 1;
            if (io_req_we) begin
                lw_addr <= {16'h0, io_req_addr}; lw_data <= io_req_wdata;
            end
        end
        if (done) ndone <= ndone + 1;
        if (rep_err) nerr <= nerr + 1;
    end

    int nchk = 0, nfail = 0;
    bit finished = 0;

    task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", what, got, exp);
        end
    endtask

    task automatic clear_log();
        nrd = 0; nwr = 0; nio = 0; ndone = 0; nerr = 0;
        lw_addr = 0; lw_data = 0; lrseg = 0;
    endtask

    task automatic run_vec(input int i);
        vec_t v;
        int waited;
        v = VEC[i];
        lat = i % 3;
        @(negedge clk);
        ld_regs = 1; ld_src = v.si; ld_dst = v.di; ld_cnt = v.cnt;
        ld_acc = 32'h11223344; ld_port = 16'h03AC;
        dir_set = v.dir; dir_clr = !v.dir;
        @(negedge clk);
        ld_regs = 0; dir_set = 0; dir_clr = 0;
        clear_log();
        chk($sformatf("R1 dir flag v%0d", i), {31'h0, dir_flag}, {31'h0, v.dir});
        op = v.op; size = v.sz; rep = v.rep; seg_ovr_en = v.oen; seg_ovr = v.oseg; start = 1;
        @(negedge clk);
        start = 0;
        waited = 0;
        while (ndone == 0 && waited < 200) begin
            @(negedge clk);
            waited++;
        end
        @(negedge clk);
        chk($sformatf("R8 done once v%0d", i), ndone, 1);
        chk($sformatf("R1 R2 R3 R12 src v%0d", i), src_ptr, v.e_si);
        chk($sformatf("R1 R2 R3 R12 dst v%0d", i), dst_ptr, v.e_di);
        chk($sformatf("R8 R9 R10 count v%0d", i), count, v.e_cnt);
        chk($sformatf("R6 R9 mem reads v%0d", i), nrd, {24'h0, v.e_rd});
        chk($sformatf("R5 R6 R7 mem writes v%0d", i), nwr, {24'h0, v.e_wr});
        chk($sformatf("R7 port accesses v%0d", i), nio, {24'h0, v.e_io});
        chk($sformatf("R5 R6 R7 last write addr v%0d", i), lw_addr, v.e_waddr);
        chk($sformatf("R5 R6 R7 last write data v%0d", i), lw_data, v.e_wdata);
        chk($sformatf("R4 read seg v%0d", i), {30'h0, lrseg}, {30'h0, v.e_rseg});
        chk($sformatf("R10 error pulses v%0d", i), nerr, {31'h0, v.e_err});
        chk($sformatf("R5 accumulator v%0d", i), acc, v.e_acc);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // reset state
        chk("reset busy", {31'h0, busy}, 0);
        chk("reset mem valid", {31'h0, mem_req_valid}, 0);
        chk("reset io valid", {31'h0, io_req_valid}, 0);
        chk("reset pointers", src_ptr | dst_ptr | count, 0);
        rst_n = 1;
        for (int i = 0; i < NV; i++) run_vec(i);
        // R9: zero-count repeat yields done one cycle after start, idle throughout
        @(negedge clk);
        ld_regs = 1; ld_cnt = 0; ld_src = 32'h77; ld_dst = 32'h88;
        @(negedge clk);
        ld_regs = 0; clear_log();
        op = 3'd1; rep = 1; start = 1;
        @(negedge clk);
        start = 0;
        chk("R9 immediate done", {31'h0, done}, 1);
        chk("R9 not busy", {31'h0, busy}, 0);
        chk("R9 dst unchanged", dst_ptr, 32'h88);
        // R11: handshakes held under latency
        chk("R11 held requests", hold_bad, 0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end
endmodule